// File: doc/BRIEF.md
# Four-slot TDM serial audio receiver

This block captures a time-division-multiplexed audio stream as a bit-clock slave. It runs entirely on the incoming bit clock. Each rising edge samples the frame-sync line and the serial data line. The block packs the data bits into 32-bit slot words and labels each word with its position inside the frame. A frame is four slots of 32 bits, so it lasts 128 bit-clock periods. The frame-sync line pulses high for one bit period per frame, one bit before the first bit of slot 0.

After it is enabled, the receiver discards every bit until it sees a frame-sync pulse. Only then does it lock and begin producing words. The channel order is therefore correct from the first word, whatever bit position the stream happened to be at when capture began. The receiver knows the frame length, so its bit counter runs freely between pulses. Every pulse restarts that counter. A pulse that arrives anywhere other than the last bit of a frame sets a sticky error flag and forces a resynchronisation. A separate flag reports whether the words handed downstream still divide into whole frames. A downstream consumer that groups words in fours can detect a channel slip from that flag.

Top module: `tdm_slot_rx`

## Requirements
- R1: While reset is held, and after reset until the first pulse is locked, valid_o, locked_o and misalign_o are low and aligned_o is high.
- R2: After enable rises, bits sampled before the first frame-sync pulse produce no word. locked_o rises in the cycle after the edge that sampled the first pulse.
- R3: The first word after a pulse sampled on edge t is made of the data bits sampled on edges t+1 to t+32, most significant bit first. All 32 bits pass unmodified, so a 24-bit sample that is left-justified over a zero low byte arrives intact. valid_o is high for exactly one cycle, after the edge that sampled the word's last bit.
- R4: slot_o is 0 for the first word after a pulse and rises by one for each later word, one word per 32 bit periods. With no further pulse it wraps from 3 back to 0 after 128 bits.
- R5: A pulse sampled on the same edge as the last bit of slot 3, 128 edges after the previous pulse, continues the stream with no gap and no error.
- R6: A pulse sampled while locked at any other bit position sets misalign_o from the next cycle. misalign_o stays set until enable drops or reset. The partially received word is discarded and the next word is slot 0. A word whose last bit falls on that edge is still delivered.
- R7: aligned_o is high exactly when the number of words delivered since enable, taken modulo 4, equals the number of slots already completed in the current frame. A resynchronisation in mid-frame therefore drives it low.
- R8: An edge that samples enable low clears the lock, the error flag and the delivered-word count, and suppresses any word on that edge. Capture after that needs a new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; all sampling on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Capture enable; low drops lock |
| fsync_i | input | 1 | Frame-sync pulse, one bit period wide |
| sdata_i | input | 1 | Serial data, MSB first |
| word_o | output | SLOT_W | Received slot word |
| slot_o | output | $clog2(SLOTS) | Slot index of word_o |
| valid_o | output | 1 | One-cycle strobe for word_o and slot_o |
| locked_o | output | 1 | Receiver has locked to a frame-sync pulse |
| aligned_o | output | 1 | Delivered words form whole frames so far |
| misalign_o | output | 1 | Sticky: pulse seen at an unexpected bit |

## Verification
The bound checker watches, on every cycle, the properties that follow from the ports alone. It confirms that no word appears without lock and that lock only follows a sampled pulse. It confirms that strobes never come back to back and that slot indices run 0, 1, 2, 3 in order while no misalignment is flagged. It also confirms that the error flag is sticky, and that a low enable empties the outputs on the next cycle. Other properties depend on the bit-exact contents of each word and on the delivered-word count against the frame position. These are the word contents, the drop of a partial word at a resynchronisation, and the low aligned flag after a mid-frame pulse. The bench shows these by comparing every cycle against a behavioural model fed by scenarios that cover noise before lock, back-to-back frames, an early pulse and re-enable.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

  typedef enum logic [1:0] {
    TRK_OFF  = 2'd0,
    TRK_HUNT = 2'd1,
    TRK_LOCK = 2'd2
  } trk_state_e;

  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/tdm_frame_tracker.sv
module tdm_frame_tracker
  import tdm_rx_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int SLOT_W = 32,
  localparam int SW_W  = $clog2(SLOT_W),
  localparam int SL_W  = $clog2(SLOTS),
  localparam int FB_W  = SW_W + SL_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            fsync_i,
  output logic            locked_o,
  output logic            word_end_o,
  output logic [SL_W-1:0] slot_idx_o,
  output logic            misalign_o
);

  localparam logic [FB_W-1:0] LAST_BIT = FB_W'(SLOTS * SLOT_W - 1);
  localparam logic [SW_W-1:0] SLOT_END = SW_W'(SLOT_W - 1);

  trk_state_e      state_q;
  logic [FB_W-1:0] cnt_q;
  logic            mis_q;
  logic            lock_w;

  assign lock_w = (state_q == TRK_LOCK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TRK_OFF;
      cnt_q   <= '0;
      mis_q   <= 1'b0;
    end else if (!en_i) begin
      state_q <= TRK_OFF;
      cnt_q   <= '0;
      mis_q   <= 1'b0;
    end else begin
      unique case (state_q)
        TRK_LOCK: begin
          if (fsync_i) begin
            if (cnt_q != LAST_BIT) mis_q <= 1'b1;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;  // free-runs at the programmed frame length
          end
        end
        default: begin
          // bits before the first pulse are never counted
          if (fsync_i) begin
            state_q <= TRK_LOCK;
            cnt_q   <= '0;
          end else begin
            state_q <= TRK_HUNT;
          end
        end
      endcase
    end
  end

  assign locked_o   = lock_w;
  assign word_end_o = en_i & lock_w & (cnt_q[SW_W-1:0] == SLOT_END);
  assign slot_idx_o = cnt_q[FB_W-1:SW_W];
  assign misalign_o = mis_q;

endmodule

// File: rtl/tdm_shift_deser.sv
module tdm_shift_deser #(
  parameter int SLOTS  = 4,
  parameter int SLOT_W = 32,
  localparam int SL_W  = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_en_i,
  input  logic              sdata_i,
  input  logic              word_end_i,
  input  logic [SL_W-1:0]   slot_idx_i,
  output logic [SLOT_W-1:0] word_o,
  output logic [SL_W-1:0]   slot_o,
  output logic              valid_o
);

  logic [SLOT_W-2:0] sh_q;
  logic [SLOT_W-1:0] word_q;
  logic [SL_W-1:0]   slot_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else if (shift_en_i) begin
      sh_q <= {sh_q[SLOT_W-3:0], sdata_i};
    end
  end

  // final bit bypasses the shifter so the word is out one edge earlier
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      slot_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= word_end_i;
      if (word_end_i) begin
        word_q <= {sh_q, sdata_i};
        slot_q <= slot_idx_i;
      end
    end
  end

  assign word_o  = word_q;
  assign slot_o  = slot_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/tdm_align_monitor.sv
module tdm_align_monitor #(
  parameter int SLOTS = 4,
  localparam int SL_W = $clog2(SLOTS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            word_end_i,
  input  logic [SL_W-1:0] slot_pos_i,
  output logic            aligned_o
);

  logic [SL_W-1:0] wcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
    end else if (!en_i) begin
      wcnt_q <= '0;
    end else if (word_end_i) begin
      wcnt_q <= wcnt_q + 1'b1;  // wraps modulo SLOTS
    end
  end

  assign aligned_o = (wcnt_q == slot_pos_i);

endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx #(
  parameter int SLOTS  = 4,
  parameter int SLOT_W = 32,
  localparam int SL_W  = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              fsync_i,
  input  logic              sdata_i,
  output logic [SLOT_W-1:0] word_o,
  output logic [SL_W-1:0]   slot_o,
  output logic              valid_o,
  output logic              locked_o,
  output logic              aligned_o,
  output logic              misalign_o
);

  logic            locked_w;
  logic            word_end_w;
  logic [SL_W-1:0] slot_idx_w;

  tdm_frame_tracker #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_trk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .fsync_i    (fsync_i),
    .locked_o   (locked_w),
    .word_end_o (word_end_w),
    .slot_idx_o (slot_idx_w),
    .misalign_o (misalign_o)
  );

  tdm_shift_deser #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_des (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (locked_w),
    .sdata_i    (sdata_i),
    .word_end_i (word_end_w),
    .slot_idx_i (slot_idx_w),
    .word_o     (word_o),
    .slot_o     (slot_o),
    .valid_o    (valid_o)
  );

  tdm_align_monitor #(.SLOTS(SLOTS)) u_aln (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .word_end_i (word_end_w),
    .slot_pos_i (slot_idx_w),
    .aligned_o  (aligned_o)
  );

  assign locked_o = locked_w;

endmodule

// File: rtl/tdm_slot_rx_chk.sv
module tdm_slot_rx_chk #(
  parameter int SLOTS  = 4,
  parameter int SLOT_W = 32,
  localparam int SL_W  = $clog2(SLOTS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              fsync_i,
  input logic              sdata_i,
  input logic [SLOT_W-1:0] word_o,
  input logic [SL_W-1:0]   slot_o,
  input logic              valid_o,
  input logic              locked_o,
  input logic              aligned_o,
  input logic              misalign_o
);

  logic            have_prev_q;
  logic [SL_W-1:0] prev_slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_prev_q <= 1'b0;
      prev_slot_q <= '0;
    end else if (!en_i) begin
      have_prev_q <= 1'b0;
    end else if (valid_o) begin
      have_prev_q <= 1'b1;
      prev_slot_q <= slot_o;
    end
  end

  p_valid_locked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> locked_o);

  p_lock_from_sync_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> ($past(fsync_i) && $past(en_i)));

  p_first_slot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !have_prev_q) |-> (slot_o == '0));

  p_strobe_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_slot_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && have_prev_q && !misalign_o) |-> (slot_o == SL_W'(prev_slot_q + 1'b1)));

  p_mis_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(misalign_o) |-> ($past(fsync_i) && $past(locked_o)));

  p_mis_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (misalign_o && en_i) |=> misalign_o);

  p_unlocked_aligned_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> aligned_o);

  p_disable_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!locked_o && !valid_o && !misalign_o));

  // word_o and sdata_i are covered by the bench
  logic unused_w;
  assign unused_w = ^{word_o, sdata_i};

endmodule

bind tdm_slot_rx tdm_slot_rx_chk #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .fsync_i    (fsync_i),
  .sdata_i    (sdata_i),
  .word_o     (word_o),
  .slot_o     (slot_o),
  .valid_o    (valid_o),
  .locked_o   (locked_o),
  .aligned_o  (aligned_o),
  .misalign_o (misalign_o)
);

// File: tb/sim_tdm_slot_rx.sv
`timescale 1ns/1ps
module sim_tdm_slot_rx;
  localparam int SLOTS = 4;
  localparam int SW    = 32;
  localparam int FBITS = SLOTS * SW;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, fs = 1'b0, sd = 1'b0;
  logic [SW-1:0] word;
  logic [1:0]    slot;
  logic          valid, locked, aligned, misalign;

  always #2.5 clk = ~clk;

  tdm_slot_rx #(.SLOTS(SLOTS), .SLOT_W(SW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .fsync_i(fs), .sdata_i(sd),
    .word_o(word), .slot_o(slot), .valid_o(valid), .locked_o(locked),
    .aligned_o(aligned), .misalign_o(misalign)
  );

  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit            m_locked = 0, m_mis = 0, m_valid = 0;
  int            m_pos = 0, m_slot = 0, m_deliv = 0, m_wslot = 0;
  logic [SW-1:0] m_word = '0;
  bit            q[$];

  always @(posedge clk) begin
    if (!rst_n || !en) begin
      m_locked = 0; m_mis = 0; m_valid = 0; m_pos = 0; m_slot = 0; m_deliv = 0;
      q.delete();
    end else begin
      m_valid = 0;
      if (m_locked) begin
        q.push_back(sd);
        if (q.size() == SW) begin
          for (int i = 0; i < SW; i++) m_word[SW-1-i] = q[i];
          m_valid = 1; m_wslot = m_slot;
          m_slot = (m_slot + 1) % SLOTS;
          m_deliv++;
          q.delete();
        end
      end
      if (fs) begin
        if (m_locked && m_pos != FBITS - 1) m_mis = 1;
        m_locked = 1; m_pos = 0; m_slot = 0;
        q.delete();
      end else if (m_locked) begin
        m_pos = (m_pos + 1) % FBITS;
      end
    end
  end

  always @(negedge clk) begin
    chk("R3/R4 valid", valid, m_valid);
    if (m_valid) begin
      chk("R3 word", word, m_word);
      chk("R4 slot", slot, m_wslot);
    end
    chk("R2 locked", locked, m_locked);
    chk("R6 misalign", misalign, m_mis);
    chk("R7 aligned", aligned, ((m_deliv % SLOTS) == m_slot));
  end

  logic [33:0] got[$];
  logic [33:0] expq[$];
  always @(negedge clk) if (valid) got.push_back({slot, word});

  task automatic tick(input logic f, input logic d);
    fs = f; sd = d;
    @(negedge clk);
  endtask

  task automatic noise(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'($urandom));
  endtask

  task automatic send_frames(input int n, input bit tail_sync);
    for (int f = 0; f < n; f++) begin
      logic [SW-1:0] w[SLOTS];
      for (int s = 0; s < SLOTS; s++) begin
        w[s] = {24'($urandom), 8'h00};
        expq.push_back({2'(s), w[s]});
      end
      for (int s = 0; s < SLOTS; s++)
        for (int b = SW - 1; b >= 0; b--)
          tick((s == SLOTS - 1 && b == 0) && (f < n - 1 || tail_sync), w[s][b]);
    end
  endtask

  task automatic cmp_stream(input string req);
    #1;
    chk({req, " count"}, got.size(), expq.size());
    for (int i = 0; i < expq.size() && i < got.size(); i++) chk(req, got[i], expq[i]);
    got.delete(); expq.delete();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL R5 watchdog actual=%0d expected<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", valid, 0);
    chk("R1 locked", locked, 0);
    chk("R1 misalign", misalign, 0);
    chk("R1 aligned", aligned, 1);
    rst_n = 1'b1;
    @(negedge clk);
    en = 1'b1;
    noise(45);
    chk("R2 no lock before pulse", locked, 0);
    chk("R2 no words before pulse", got.size(), 0);

    tick(1'b1, 1'($urandom));
    chk("R2 lock after pulse", locked, 1);
    send_frames(3, 1'b1);
    cmp_stream("R5 back-to-back frames");
    chk("R5 no error", misalign, 0);
    chk("R7 aligned at frame edge", aligned, 1);

    noise(70);            // two words of slot 0/1, then a partial slot 2
    tick(1'b1, 1'b0);     // early pulse
    chk("R6 misalign set", misalign, 1);
    chk("R7 slip shown", aligned, 0);
    got.delete();
    send_frames(2, 1'b0);
    cmp_stream("R6 realigned to slot 0");
    noise(5);
    chk("R6 sticky", misalign, 1);
    chk("R7 slip persists", aligned, 0);

    en = 1'b0;
    tick(1'b0, 1'b0);
    chk("R8 lock cleared", locked, 0);
    chk("R8 error cleared", misalign, 0);
    chk("R8 aligned reset", aligned, 1);
    en = 1'b1;
    got.delete();
    noise(100);
    chk("R8 no words before new pulse", got.size(), 0);
    tick(1'b1, 1'b1);
    send_frames(1, 1'b0);
    noise(SW);            // free-running wrap gives a slot 0 word
    #1;
    chk("R4 wrap count", got.size(), 5);
    if (got.size() == 5) chk("R4 wrap slot", got[4][33:32], 0);
    if (got.size() >= 1) chk("R8 first word after relock", got[0], expq[0]);
    got.delete(); expq.delete();

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule